// File: doc/BRIEF.md
# SPI Subaddressed Register Write Slave

This block is a receive-only serial slave that loads a bank of sixteen 8-bit configuration registers. A host selects the block by driving the active-low select line low. It then clocks in one subaddress byte and after it any number of data bytes. The low four bits of the subaddress give the first register to load. Each later data byte goes into the current register, and the index then moves on to the next register. After register 15 it continues at register 0.

The three serial lines are not clocked into the design directly. Each passes through a two-flop synchronizer in the system clock domain, which must run at 16 MHz or faster. Rising edges of the serial clock are found from the synchronized samples. This means an idle-low serial clock (polarity 0, phase 0) and an idle-high one (polarity 1, phase 1) both work with no mode setting. In both cases data is taken on the rising edge, most significant bit first. Every register update also appears for one cycle on a write strobe, together with the index and the data, so that the order of writes can be observed. All registers are visible at all times on a flat parallel bus.

Top module: `spi_regwr_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, every register reads 0 and the write strobe is low.
- R2: With an idle-low serial clock, each byte is taken from the data line on eight rising clock edges, bit 7 first.
- R3: With an idle-high serial clock, frames are received the same way, taking data on rising edges, with no configuration change.
- R4: The first byte of a frame selects the starting register through its bits 3..0, and its bits 7..4 are ignored. A frame holding only this byte writes nothing.
- R5: Each complete data byte gives exactly one single-cycle write strobe carrying the index and data. The register shows that data on the next cycle. Registers change at no other time.
- R6: After each data byte the register index advances by one, and from 15 it goes to 0.
- R7: Raising select before a byte is complete discards that byte. No strobe is produced and no register changes.
- R8: While select is high, serial clock edges are ignored. Each fall of select starts a new frame that begins with a subaddress byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 MHz |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, either idle level |
| sdi | input | 1 | Serial data, sampled on rising sck |
| regs_o | output | 128 | All registers; register k occupies bits 8k+7..8k |
| wr_stb | output | 1 | One-cycle pulse for each register write |
| wr_idx | output | 4 | Index of the register being written |
| wr_data | output | 8 | Data being written |

## Verification
In one clock cycle, the block must both load a data byte into register 15 and advance its index, which wraps to 0. The bench provokes this with a burst that starts at subaddress 14 and carries four bytes. It checks that the strobes arrive with indices 14, 15, 0 and 1, in that order, each with its own data.

A second overlap happens when select rises. At that moment a byte has just been committed and the next byte is partly shifted in. The bench sends one full byte, then five more bits, and then deasserts select. It expects exactly one strobe and expects the next register to stay unchanged.

// File: rtl/spi_regwr_pkg.sv
`timescale 1ns/1ps
package spi_regwr_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned NREG   = 1 << ADDR_W;
    localparam int unsigned CNT_W  = $clog2(DATA_W);

    typedef enum logic {
        FR_SUBADDR,
        FR_PAYLOAD
    } frame_st_e;

    typedef struct packed {
        logic              stb;
        logic [ADDR_W-1:0] idx;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    function automatic logic [ADDR_W-1:0] idx_step(input logic [ADDR_W-1:0] cur);
        return cur + ADDR_W'(1);
    endfunction
endpackage

// File: rtl/spi_line_sync.sv
`timescale 1ns/1ps
module spi_line_sync #(
    parameter int unsigned    W       = 3,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[g]}};
            else     chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_frame_rx.sv
`timescale 1ns/1ps
module spi_frame_rx
    import spi_regwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sel_s,
    input  logic    sck_s,
    input  logic    sdi_s,
    output reg_wr_t wr
);
    logic              sck_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] shreg;
    logic [ADDR_W-1:0] idx;
    frame_st_e         state;
    logic              rise;
    logic [DATA_W-1:0] rx_byte;

    // rising serial clock, only inside a selected frame
    assign rise    = sck_s & ~sck_q & ~sel_s;
    assign rx_byte = {shreg, sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            idx     <= '0;
            state   <= FR_SUBADDR;
            wr      <= '0;
        end else begin
            sck_q  <= sck_s;
            wr.stb <= 1'b0;
            if (sel_s) begin
                // deselected: drop any partial byte, rearm for a subaddress
                bit_cnt <= '0;
                state   <= FR_SUBADDR;
            end else if (rise) begin
                shreg <= rx_byte[DATA_W-2:0];
                if (bit_cnt == CNT_W'(DATA_W-1)) begin
                    bit_cnt <= '0;
                    if (state == FR_SUBADDR) begin
                        idx   <= rx_byte[ADDR_W-1:0];
                        state <= FR_PAYLOAD;
                    end else begin
                        wr.stb  <= 1'b1;
                        wr.idx  <= idx;
                        wr.data <= rx_byte;
                        idx     <= idx_step(idx);
                    end
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/spi_reg_bank.sv
`timescale 1ns/1ps
module spi_reg_bank
    import spi_regwr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  reg_wr_t                wr,
    output logic [NREG*DATA_W-1:0] regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] val;
        always_ff @(posedge clk) begin
            if (rst)                                     val <= '0;
            else if (wr.stb && wr.idx == ADDR_W'(g))     val <= wr.data;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = val;
    end
endmodule

// File: rtl/spi_regwr_slave.sv
`timescale 1ns/1ps
module spi_regwr_slave
    import spi_regwr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sel_n,
    input  logic                   sck,
    input  logic                   sdi,
    output logic [NREG*DATA_W-1:0] regs_o,
    output logic                   wr_stb,
    output logic [ADDR_W-1:0]      wr_idx,
    output logic [DATA_W-1:0]      wr_data
);
    logic [2:0] lines_s;
    reg_wr_t    wr;

    spi_line_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sdi, sck, sel_n}),
        .q   (lines_s)
    );

    spi_frame_rx u_rx (
        .clk   (clk),
        .rst   (rst),
        .sel_s (lines_s[0]),
        .sck_s (lines_s[1]),
        .sdi_s (lines_s[2]),
        .wr    (wr)
    );

    spi_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .regs_flat (regs_o)
    );

    assign wr_stb  = wr.stb;
    assign wr_idx  = wr.idx;
    assign wr_data = wr.data;
endmodule

// File: rtl/spi_regwr_chk.sv
`timescale 1ns/1ps
module spi_regwr_chk
    import spi_regwr_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   sel_n,
    input logic [NREG*DATA_W-1:0] regs_o,
    input logic                   wr_stb,
    input logic [ADDR_W-1:0]      wr_idx,
    input logic [DATA_W-1:0]      wr_data
);
    logic [ADDR_W-1:0] idx_q;
    logic [DATA_W-1:0] dat_q;
    logic [2:0]        idle_cnt;

    always_ff @(posedge clk) begin
        idx_q <= wr_idx;
        dat_q <= wr_data;
        if (rst || !sel_n)       idle_cnt <= '0;
        else if (idle_cnt != '1) idle_cnt <= idle_cnt + 3'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!wr_stb && regs_o == '0));

    p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    p_reg_written_r5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (regs_o[idx_q*DATA_W +: DATA_W] == dat_q));

    p_regs_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(regs_o));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt >= 3'd4) |-> !wr_stb);
endmodule

bind spi_regwr_slave spi_regwr_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_n   (sel_n),
    .regs_o  (regs_o),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
);

// File: tb/spi_regwr_slave_tb.sv
`timescale 1ns/1ps
module spi_regwr_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 100;

    typedef struct {
        int    idx;
        int    data;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_n = 1'b1;
    logic         sck = 1'b0;
    logic         sdi = 1'b0;
    logic [127:0] regs_o;
    logic         wr_stb;
    logic [3:0]   wr_idx;
    logic [7:0]   wr_data;

    int         checks = 0;
    int         errors = 0;
    int         strobes = 0;
    exp_t       exp_q[$];
    logic [7:0] tx_q[$];
    logic [7:0] model [16];
    bit         pend = 0;
    int         pend_idx;
    int         pend_data;
    string      pend_tag;

    spi_regwr_slave u_dut (
        .clk     (clk),
        .rst     (rst),
        .sel_n   (sel_n),
        .sck     (sck),
        .sdi     (sdi),
        .regs_o  (regs_o),
        .wr_stb  (wr_stb),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected writes as strobes appear, then checks the register
    always @(negedge clk) begin
        if (!rst) begin
            if (pend) begin
                check(regs_o[pend_idx*8 +: 8] == pend_data[7:0], pend_tag,
                      "register content after strobe", regs_o[pend_idx*8 +: 8], pend_data);
                pend = 0;
            end
            if (wr_stb) begin
                strobes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected strobe idx", wr_idx, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(wr_idx == e.idx[3:0], e.tag, "strobe index", wr_idx, e.idx);
                    check(wr_data == e.data[7:0], e.tag, "strobe data", wr_data, e.data);
                    pend      = 1;
                    pend_idx  = e.idx;
                    pend_data = e.data;
                    pend_tag  = e.tag;
                end
            end
        end
    end

    task automatic send_bits(input logic [7:0] b, input bit cpol, input int n);
        for (int i = 0; i < n; i++) begin
            if (cpol) sck = 1'b0;
            sdi = b[7-i];
            #(HALF_SCK);
            sck = 1'b1;
            #(HALF_SCK);
            if (!cpol) sck = 1'b0;
        end
    endtask

    // one frame: subaddress, the bytes in tx_q, then optional partial bits
    task automatic run_frame(input bit cpol, input logic [7:0] sub,
                             input string tag, input int tail_bits);
        int idx;
        sck = cpol;
        #(HALF_SCK);
        sel_n = 1'b0;
        #300;
        send_bits(sub, cpol, 8);
        idx = int'(sub[3:0]);
        while (tx_q.size() > 0) begin
            logic [7:0] b;
            b = tx_q.pop_front();
            exp_q.push_back('{idx, int'(b), tag});
            model[idx] = b;
            idx = (idx + 1) % 16;
            send_bits(b, cpol, 8);
        end
        if (tail_bits > 0) send_bits(8'hFF, cpol, tail_bits);
        #300;
        sck = cpol;
        sel_n = 1'b1;
        #400;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(regs_o == '0, "R1", "registers after reset", regs_o[63:0], 0);
        check(wr_stb == 1'b0, "R1", "strobe after reset", wr_stb, 0);

        // R2: idle-low clock, two bytes from register 3
        tx_q = '{8'hA5, 8'h3C};
        run_frame(1'b0, 8'h03, "R2", 0);

        // R3 + R4: idle-high clock, upper subaddress bits ignored (0xF7 -> 7)
        tx_q = '{8'h81, 8'h7E, 8'hC3};
        run_frame(1'b1, 8'hF7, "R3", 0);

        // R6: burst across the wrap 14,15,0,1
        tx_q = '{8'h11, 8'h22, 8'h33, 8'h44};
        run_frame(1'b0, 8'h0E, "R6", 0);

        // R7: one full byte then 5 bits, select rises
        s0 = strobes;
        tx_q = '{8'h99};
        run_frame(1'b1, 8'h05, "R7", 5);
        check(strobes == s0 + 1, "R7", "strobes on aborted frame", strobes - s0, 1);
        check(regs_o[6*8 +: 8] == model[6], "R7", "reg6 untouched by partial byte",
              regs_o[6*8 +: 8], model[6]);

        // R8: clock activity while deselected is ignored
        s0 = strobes;
        sel_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sdi = i[0];
            sck = ~sck;
            #(HALF_SCK);
        end
        sck = 1'b0;
        #400;
        check(strobes == s0, "R8", "strobes while deselected", strobes - s0, 0);
        check(regs_o[6*8 +: 8] == model[6], "R8", "reg6 after idle clocking",
              regs_o[6*8 +: 8], model[6]);

        // R8: next frame restarts at a subaddress after the abort
        tx_q = '{8'h5A};
        run_frame(1'b0, 8'h0A, "R8", 0);

        // R4: subaddress-only frame writes nothing
        s0 = strobes;
        run_frame(1'b0, 8'h62, "R4", 0);
        check(strobes == s0, "R4", "strobes for subaddress-only frame", strobes - s0, 0);

        #1000;
        for (int r = 0; r < 16; r++)
            check(regs_o[r*8 +: 8] == model[r], "R5", $sformatf("final reg %0d", r),
                  regs_o[r*8 +: 8], model[r]);
        check(exp_q.size() == 0, "R5", "writes still outstanding", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule